// File: doc/BRIEF.md
# Encoder Position Counter with Event Latching

This block keeps a 32-bit signed-agnostic position integral for a rotary or linear encoder. Each cycle in which the count strobe is high moves the count one step up or down, as chosen by the direction input. Around that counter sit the event paths. Index, strobe, unit-time and software events can clear the count, load it from a preset value, or take snapshots of it. The quadrature decoder in front of it and the compare logic behind it are separate blocks.

All inputs are synchronous single-bit levels or configuration fields, and all outputs are plain registered status. There is no data stream at this boundary, so no valid/ready handshake is used and nothing stalls the block. Index and strobe are edge-detected internally. An edge produces its effect at the first clock edge that sees the new level, and the effect is visible on the outputs right after that edge.

Top module: `enc_pos_tracker`

## Requirements
- R1: While `enable` is low, the count, both snapshot registers, the direction snapshot and every flag are held at zero one cycle later. The configuration inputs are not stored by the block.
- R2: While enabled, a cycle with `cnt_pulse` high adds one to the count when `cnt_dir` is 1 (forward) and subtracts one when `cnt_dir` is 0 (reverse). A cycle without `cnt_pulse` leaves the count unchanged.
- R3: Counting up from the wrap limit gives 0 and sets the sticky `ovf_flag`. The wrap limit is `max_pos` when `rst_mode` is 1, and 0xFFFFFFFF for every other mode.
- R4: Counting down from 0 gives the wrap limit and sets the sticky `unf_flag`.
- R5: With `rst_mode` = 0, every rising edge of `index_in` clears the count.
- R6: With `rst_mode` = 2, only the rising edge of `index_in` that arrives while `first_idx_flag` is low clears the count.
- R7: With `rst_mode` = 3, a cycle with `unit_evt` high clears the count, even when a count pulse arrives in the same cycle.
- R8: `idx_init_mode` loads `preset` into the count on the rising edge of `index_in` for code 2 and on the falling edge for code 3. Codes 0 and 1 have no effect.
- R9: `stb_init_mode` loads `preset` on the rising edge of `strobe_in` for code 2. For code 3 it loads on the rising edge when the direction is forward and on the falling edge when it is reverse. Codes 0 and 1 have no effect.
- R10: `sw_init` loads `preset` in every cycle in which it is high. Any load takes priority over the reset sources and over a count pulse in the same cycle.
- R11: `idx_latch_mode` copies the pre-update count into `idx_latch` and sets the sticky `idx_latch_evt`. Code 1 acts on the rising edge of `index_in`, code 2 on the falling edge, and code 3 on the rising edge while also copying `cnt_dir` into `dir_latch`. Code 0 latches nothing.
- R12: `strobe_latch_dir` = 0 copies the count into `stb_latch` on the rising edge of `strobe_in`. When it is 1, the copy is made on the rising edge for forward direction and on the falling edge for reverse. Each copy sets the sticky `stb_latch_evt`.
- R13: The first rising edge of `index_in` after enable sets the sticky `first_idx_flag` and records `cnt_dir` in `first_idx_dir`. Later edges leave both unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Counter enable; low clears all state |
| cnt_pulse | input | 1 | One count step in this cycle |
| cnt_dir | input | 1 | 1 forward (up), 0 reverse (down) |
| index_in | input | 1 | Conditioned index level |
| strobe_in | input | 1 | Conditioned strobe level |
| unit_evt | input | 1 | Unit-time event pulse |
| rst_mode | input | 2 | Reset source: 0 every index, 1 at wrap limit, 2 first index, 3 unit time |
| idx_init_mode | input | 2 | Index-driven preset load select |
| stb_init_mode | input | 2 | Strobe-driven preset load select |
| sw_init | input | 1 | Level-held software preset load |
| idx_latch_mode | input | 2 | Index snapshot select |
| strobe_latch_dir | input | 1 | Strobe snapshot edge follows direction |
| preset | input | 32 | Value loaded by init events |
| max_pos | input | 32 | Wrap limit when rst_mode is 1 |
| position | output | 32 | Live count |
| idx_latch | output | 32 | Count captured on index |
| stb_latch | output | 32 | Count captured on strobe |
| dir_latch | output | 1 | Direction captured in index marker mode |
| first_idx_flag | output | 1 | Sticky: first index seen |
| first_idx_dir | output | 1 | Direction at first index |
| ovf_flag | output | 1 | Sticky overflow |
| unf_flag | output | 1 | Sticky underflow |
| idx_latch_evt | output | 1 | Sticky: index snapshot taken |
| stb_latch_evt | output | 1 | Sticky: strobe snapshot taken |

## Verification
The assertions check on every cycle the things that follow from one cycle to the next. These are the clearing effect of a low enable, single steps up and down, wrap-around with its sticky flag when no event interferes, software preset loads, unit-time clears, and the persistence of the sticky flags. Some behaviour can only be shown by the bench's ordered scenarios. That covers the edge polarity chosen by each event code, the direction-dependent strobe edges, the first-index-only reset, the inert codes, and the relative priority of loads, clears and steps. All of these depend on a prepared history of index and strobe levels.

// File: rtl/enc_pos_pkg.sv
package enc_pos_pkg;
  typedef enum logic [1:0] {
    RST_EVERY_IDX = 2'd0,
    RST_AT_LIMIT  = 2'd1,
    RST_FIRST_IDX = 2'd2,
    RST_UNIT_TIME = 2'd3
  } rst_mode_e;

  typedef enum logic [1:0] {
    ILAT_NONE  = 2'd0,
    ILAT_RISE  = 2'd1,
    ILAT_FALL  = 2'd2,
    ILAT_MARK  = 2'd3
  } idx_latch_e;

  localparam logic [1:0] INIT_ON_RISE = 2'd2;
  localparam logic [1:0] INIT_ON_ALT  = 2'd3;
endpackage

// File: rtl/enc_edge_det.sv
module enc_edge_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sig;
  end

  for (genvar g = 0; g < N; g++) begin : g_edge
    assign rise[g] =  sig[g] & ~prev_q[g];
    assign fall[g] = ~sig[g] &  prev_q[g];
  end
endmodule

// File: rtl/enc_pos_core.sv
module enc_pos_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         load_preset,
  input  logic         zero_cnt,
  input  logic         step,
  input  logic         step_up,
  input  logic [W-1:0] preset,
  input  logic [W-1:0] wrap_max,
  output logic [W-1:0] pos,
  output logic         ovf,
  output logic         unf
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else if (!enable) begin
      pos <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else if (load_preset) begin
      pos <= preset;
    end else if (zero_cnt) begin
      pos <= '0;
    end else if (step) begin
      if (step_up) begin
        if (pos == wrap_max) begin
          pos <= '0;
          ovf <= 1'b1;
        end else begin
          pos <= pos + 1'b1;
        end
      end else begin
        if (pos == '0) begin
          pos <= wrap_max;
          unf <= 1'b1;
        end else begin
          pos <= pos - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/enc_event_latch.sv
module enc_event_latch #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic [W-1:0] pos,
  input  logic         dir,
  input  logic         idx_hit,
  input  logic         idx_mark,
  input  logic         stb_hit,
  input  logic         idx_rise,
  output logic [W-1:0] idx_snap,
  output logic [W-1:0] stb_snap,
  output logic         dir_snap,
  output logic         first_seen,
  output logic         first_dir,
  output logic         idx_evt,
  output logic         stb_evt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_snap   <= '0;
      stb_snap   <= '0;
      dir_snap   <= 1'b0;
      first_seen <= 1'b0;
      first_dir  <= 1'b0;
      idx_evt    <= 1'b0;
      stb_evt    <= 1'b0;
    end else if (!enable) begin
      idx_snap   <= '0;
      stb_snap   <= '0;
      dir_snap   <= 1'b0;
      first_seen <= 1'b0;
      first_dir  <= 1'b0;
      idx_evt    <= 1'b0;
      stb_evt    <= 1'b0;
    end else begin
      if (idx_hit) begin
        idx_snap <= pos;
        idx_evt  <= 1'b1;
        if (idx_mark) dir_snap <= dir;
      end
      if (stb_hit) begin
        stb_snap <= pos;
        stb_evt  <= 1'b1;
      end
      if (idx_rise && !first_seen) begin
        first_seen <= 1'b1;
        first_dir  <= dir;
      end
    end
  end
endmodule

// File: rtl/enc_pos_tracker.sv
module enc_pos_tracker
  import enc_pos_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         cnt_pulse,
  input  logic         cnt_dir,
  input  logic         index_in,
  input  logic         strobe_in,
  input  logic         unit_evt,
  input  logic [1:0]   rst_mode,
  input  logic [1:0]   idx_init_mode,
  input  logic [1:0]   stb_init_mode,
  input  logic         sw_init,
  input  logic [1:0]   idx_latch_mode,
  input  logic         strobe_latch_dir,
  input  logic [W-1:0] preset,
  input  logic [W-1:0] max_pos,
  output logic [W-1:0] position,
  output logic [W-1:0] idx_latch,
  output logic [W-1:0] stb_latch,
  output logic         dir_latch,
  output logic         first_idx_flag,
  output logic         first_idx_dir,
  output logic         ovf_flag,
  output logic         unf_flag,
  output logic         idx_latch_evt,
  output logic         stb_latch_evt
);
  localparam int IDX = 0;
  localparam int STB = 1;

  logic [1:0] rise, fall;
  logic       stb_dir_edge, idx_init_hit, stb_init_hit, load_preset, zero_cnt;
  logic       idx_hit, idx_mark, stb_hit;
  logic [W-1:0] wrap_max;
  rst_mode_e  rmode;
  idx_latch_e imode;

  enc_edge_det #(.N(2)) u_edges (
    .clk  (clk),
    .rst_n(rst_n),
    .sig  ({strobe_in, index_in}),
    .rise (rise),
    .fall (fall)
  );

  assign rmode = rst_mode_e'(rst_mode);
  assign imode = idx_latch_e'(idx_latch_mode);

  assign stb_dir_edge = cnt_dir ? rise[STB] : fall[STB];

  assign idx_init_hit = ((idx_init_mode == INIT_ON_RISE) && rise[IDX]) ||
                        ((idx_init_mode == INIT_ON_ALT)  && fall[IDX]);
  assign stb_init_hit = ((stb_init_mode == INIT_ON_RISE) && rise[STB]) ||
                        ((stb_init_mode == INIT_ON_ALT)  && stb_dir_edge);
  assign load_preset  = sw_init | idx_init_hit | stb_init_hit;

  always_comb begin
    unique case (rmode)
      RST_EVERY_IDX: zero_cnt = rise[IDX];
      RST_AT_LIMIT:  zero_cnt = 1'b0;
      RST_FIRST_IDX: zero_cnt = rise[IDX] & ~first_idx_flag;
      RST_UNIT_TIME: zero_cnt = unit_evt;
      default:       zero_cnt = 1'b0;
    endcase
  end

  assign wrap_max = (rmode == RST_AT_LIMIT) ? max_pos : {W{1'b1}};

  always_comb begin
    unique case (imode)
      ILAT_RISE: idx_hit = rise[IDX];
      ILAT_FALL: idx_hit = fall[IDX];
      ILAT_MARK: idx_hit = rise[IDX];
      default:   idx_hit = 1'b0;
    endcase
  end
  assign idx_mark = (imode == ILAT_MARK);
  assign stb_hit  = strobe_latch_dir ? stb_dir_edge : rise[STB];

  enc_pos_core #(.W(W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .load_preset(load_preset),
    .zero_cnt   (zero_cnt),
    .step       (cnt_pulse),
    .step_up    (cnt_dir),
    .preset     (preset),
    .wrap_max   (wrap_max),
    .pos        (position),
    .ovf        (ovf_flag),
    .unf        (unf_flag)
  );

  enc_event_latch #(.W(W)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .pos       (position),
    .dir       (cnt_dir),
    .idx_hit   (idx_hit),
    .idx_mark  (idx_mark),
    .stb_hit   (stb_hit),
    .idx_rise  (rise[IDX]),
    .idx_snap  (idx_latch),
    .stb_snap  (stb_latch),
    .dir_snap  (dir_latch),
    .first_seen(first_idx_flag),
    .first_dir (first_idx_dir),
    .idx_evt   (idx_latch_evt),
    .stb_evt   (stb_latch_evt)
  );
endmodule

// File: rtl/enc_pos_tracker_chk.sv
module enc_pos_tracker_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         enable,
  input logic         cnt_pulse,
  input logic         cnt_dir,
  input logic         unit_evt,
  input logic [1:0]   rst_mode,
  input logic [1:0]   idx_init_mode,
  input logic [1:0]   stb_init_mode,
  input logic         sw_init,
  input logic [W-1:0] preset,
  input logic [W-1:0] max_pos,
  input logic [W-1:0] position,
  input logic [W-1:0] idx_latch,
  input logic [W-1:0] stb_latch,
  input logic         first_idx_flag,
  input logic         ovf_flag,
  input logic         unf_flag,
  input logic         idx_latch_evt,
  input logic         stb_latch_evt
);
  logic no_load, quiet;
  assign no_load = !sw_init && !idx_init_mode[1] && !stb_init_mode[1];
  assign quiet   = enable && no_load && (rst_mode == 2'd1) && cnt_pulse;

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (position == '0) && !ovf_flag && !unf_flag && !first_idx_flag &&
                !idx_latch_evt && !stb_latch_evt && (idx_latch == '0) && (stb_latch == '0)); // R1
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && cnt_dir && (position != max_pos) |=> position == $past(position) + 1'b1); // R2
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && !cnt_dir && (position != '0) |=> position == $past(position) - 1'b1); // R2
  AST_WRAP_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && cnt_dir && (position == max_pos) |=> (position == '0) && ovf_flag); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    enable && ovf_flag |=> ovf_flag); // R3
  AST_WRAP_UNF: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && !cnt_dir && (position == '0) |=> (position == $past(max_pos)) && unf_flag); // R4
  AST_UNIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    enable && no_load && (rst_mode == 2'd3) && unit_evt |=> position == '0); // R7
  AST_SW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    enable && sw_init |=> position == $past(preset)); // R10
  AST_FIRST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    enable && first_idx_flag |=> first_idx_flag); // R13
endmodule

bind enc_pos_tracker enc_pos_tracker_chk #(.W(W)) u_chk (.*);

// File: tb/enc_pos_tracker_bench.sv
module enc_pos_tracker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SEL_POS = 0, SEL_ILAT = 1, SEL_SLAT = 2, SEL_FLAGS = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, cnt_pulse = 1'b0, cnt_dir = 1'b0;
  logic index_in = 1'b0, strobe_in = 1'b0, unit_evt = 1'b0;
  logic [1:0] rst_mode = 2'd1, idx_init_mode = 2'd0, stb_init_mode = 2'd0, idx_latch_mode = 2'd0;
  logic sw_init = 1'b0, strobe_latch_dir = 1'b0;
  logic [31:0] preset = 32'd5, max_pos = 32'd9;
  logic [31:0] position, idx_latch, stb_latch;
  logic dir_latch, first_idx_flag, first_idx_dir, ovf_flag, unf_flag, idx_latch_evt, stb_latch_evt;

  int tests = 0, fails = 0;
  bit done = 0;
  string       q_req[$];
  int          q_sel[$];
  logic [31:0] q_val[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  enc_pos_tracker u_enc_pos_tracker (.*);

  // flags order: {dir_latch, first_idx_flag, first_idx_dir, ovf, unf, idx_evt, stb_evt}
  function automatic logic [31:0] observe(int sel);
    case (sel)
      SEL_POS:  return position;
      SEL_ILAT: return idx_latch;
      SEL_SLAT: return stb_latch;
      default:  return {25'd0, dir_latch, first_idx_flag, first_idx_dir, ovf_flag,
                        unf_flag, idx_latch_evt, stb_latch_evt};
    endcase
  endfunction

  // monitor: pops expectations one half period after the edge that produced them
  initial forever begin
    @(negedge clk);
    while (q_req.size() > 0) begin
      string r; int s; logic [31:0] v, a;
      r = q_req.pop_front(); s = q_sel.pop_front(); v = q_val.pop_front();
      a = observe(s);
      tests++;
      if (a !== v) begin
        fails++;
        $display("FAIL %s sel=%0d actual=0x%08h expected=0x%08h", r, s, a, v);
      end
    end
  end

  task automatic expect_val(string r, int s, logic [31:0] v);
    q_req.push_back(r); q_sel.push_back(s); q_val.push_back(v);
  endtask

  task automatic tick();
    @(posedge clk); #1;
    cnt_pulse = 1'b0;
    unit_evt  = 1'b0;
  endtask

  task automatic pulse(logic d);
    cnt_dir = d; cnt_pulse = 1'b1; tick();
  endtask

  task automatic idx(logic v);
    index_in = v; tick();
  endtask

  task automatic stb(logic v);
    strobe_in = v; tick();
  endtask

  task automatic cycle_enable();
    enable = 1'b0; tick(); enable = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog R1 actual=timeout expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    expect_val("R1 reset pos", SEL_POS, 0);
    expect_val("R1 reset flags", SEL_FLAGS, 0);
    tick();
    enable = 1'b1;

    // R2 up/down stepping
    pulse(1); expect_val("R2 up1", SEL_POS, 1);
    pulse(1); expect_val("R2 up2", SEL_POS, 2);
    pulse(1); expect_val("R2 up3", SEL_POS, 3);
    tick();   expect_val("R2 idle", SEL_POS, 3);
    pulse(0); expect_val("R2 down", SEL_POS, 2);

    // R3 wrap at max_pos in limit mode
    for (int i = 0; i < 7; i++) pulse(1);
    expect_val("R3 at limit", SEL_POS, 9);
    pulse(1); expect_val("R3 wrap", SEL_POS, 0);
    expect_val("R3 ovf flag", SEL_FLAGS, 32'b0001000);
    // R4 underflow
    pulse(0); expect_val("R4 wrap", SEL_POS, 9);
    expect_val("R4 unf flag", SEL_FLAGS, 32'b0001100);

    // R1 disable clears
    enable = 1'b0; tick();
    expect_val("R1 disabled pos", SEL_POS, 0);
    expect_val("R1 disabled flags", SEL_FLAGS, 0);
    enable = 1'b1;

    // R3 full-range limit outside mode 1, R5 index reset, R13 first index
    rst_mode = 2'd0;
    pulse(0); expect_val("R3 full range limit", SEL_POS, 32'hFFFF_FFFF);
    cnt_dir = 1'b1;
    idx(1); expect_val("R5 index reset", SEL_POS, 0);
    expect_val("R13 first index flags", SEL_FLAGS, 32'b0110100);
    expect_val("R11 code0 no latch", SEL_ILAT, 0);
    idx(0);

    // R6 first-index-only reset
    rst_mode = 2'd2;
    pulse(1); pulse(1);
    idx(1); expect_val("R6 later index ignored", SEL_POS, 2);
    idx(0);
    cycle_enable();
    pulse(1); pulse(1); pulse(1);
    idx(1); expect_val("R6 first index reset", SEL_POS, 0);
    idx(0);
    pulse(1);
    idx(1); expect_val("R6 second index ignored", SEL_POS, 1);
    idx(0);

    // R7 unit-time reset
    rst_mode = 2'd3;
    pulse(1); expect_val("R7 pre", SEL_POS, 2);
    unit_evt = 1'b1; tick(); expect_val("R7 unit clear", SEL_POS, 0);
    unit_evt = 1'b1; pulse(1); expect_val("R7 unit beats step", SEL_POS, 0);

    // R8 index init
    rst_mode = 2'd1;
    idx_init_mode = 2'd2;
    idx(1); expect_val("R8 code2 rise load", SEL_POS, 5);
    idx(0); expect_val("R8 code2 fall none", SEL_POS, 5);
    idx_init_mode = 2'd3;
    pulse(1);
    idx(1); expect_val("R8 code3 rise none", SEL_POS, 6);
    idx(0); expect_val("R8 code3 fall load", SEL_POS, 5);
    idx_init_mode = 2'd1;
    pulse(1);
    idx(1); expect_val("R8 code1 inert", SEL_POS, 6);
    idx(0);
    idx_init_mode = 2'd0;

    // R9 strobe init
    stb_init_mode = 2'd2;
    stb(1); expect_val("R9 code2 rise load", SEL_POS, 5);
    stb(0);
    stb_init_mode = 2'd3;
    pulse(0); expect_val("R9 pre reverse", SEL_POS, 4);
    stb(1); expect_val("R9 reverse rise none", SEL_POS, 4);
    stb(0); expect_val("R9 reverse fall load", SEL_POS, 5);
    pulse(1);
    stb(1); expect_val("R9 forward rise load", SEL_POS, 5);
    stb(0); expect_val("R9 forward fall none", SEL_POS, 5);
    stb_init_mode = 2'd0;

    // R10 software init, level held, beats step
    sw_init = 1'b1;
    pulse(1); expect_val("R10 init beats step", SEL_POS, 5);
    pulse(1); expect_val("R10 level held", SEL_POS, 5);
    sw_init = 1'b0;
    pulse(1); expect_val("R10 released", SEL_POS, 6);

    // R11 index latch
    cycle_enable();
    expect_val("R1 latches cleared", SEL_ILAT, 0);
    expect_val("R1 strobe latch cleared", SEL_SLAT, 0);
    pulse(1); pulse(1); pulse(1);
    idx_latch_mode = 2'd1;
    idx(1); expect_val("R11 code1 rise", SEL_ILAT, 3);
    expect_val("R11 evt flags", SEL_FLAGS, 32'b0110010);
    cnt_pulse = 1'b1; idx(0); expect_val("R11 code1 fall none", SEL_ILAT, 3);
    idx_latch_mode = 2'd2;
    pulse(1);
    idx(1); expect_val("R11 code2 rise none", SEL_ILAT, 3);
    idx(0); expect_val("R11 code2 fall", SEL_ILAT, 5);
    idx_latch_mode = 2'd3;
    pulse(0);
    idx(1); expect_val("R11 code3 reverse", SEL_ILAT, 4);
    expect_val("R11 dir latch 0", SEL_FLAGS, 32'b0110010);
    idx(0);
    pulse(1);
    idx(1); expect_val("R11 code3 forward", SEL_ILAT, 5);
    expect_val("R11 dir latch 1", SEL_FLAGS, 32'b1110010);
    idx(0);

    // R12 strobe latch
    stb(1); expect_val("R12 rise latch", SEL_SLAT, 5);
    pulse(1);
    stb(0); expect_val("R12 fall ignored", SEL_SLAT, 5);
    strobe_latch_dir = 1'b1;
    cnt_dir = 1'b0;
    stb(1); expect_val("R12 reverse rise none", SEL_SLAT, 5);
    stb(0); expect_val("R12 reverse fall", SEL_SLAT, 6);
    cnt_dir = 1'b1;
    stb(1); expect_val("R12 forward rise", SEL_SLAT, 6);
    pulse(1);
    stb(0); expect_val("R12 forward fall none", SEL_SLAT, 6);
    stb(1); expect_val("R12 forward rise again", SEL_SLAT, 7);
    expect_val("R12 evt flags", SEL_FLAGS, 32'b1110011);

    // R1 final clear
    enable = 1'b0; tick();
    expect_val("R1 final pos", SEL_POS, 0);
    expect_val("R1 final flags", SEL_FLAGS, 0);
    expect_val("R1 final ilat", SEL_ILAT, 0);

    repeat (3) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule